// File: doc/BRIEF.md
# Redundant SAR Decision Corrector

This block turns the raw decision word of a redundant successive-approximation search into a plain binary output code. The search makes 13 comparator decisions. Each decision carries a fixed integer weight in LSB units. Several of those weights overlap, so a decision made wrongly in an early cycle can be absorbed by the later cycles. The corrected code is the sum of the weights of the decisions that came out as one. That sum needs only additions: no offset is subtracted and no clamp is applied. The weights add up to exactly full scale, so no decision word can produce a carry out of the code width.

The weight table is a packed parameter, one entry per raw bit. Elaboration checks reject any table that could not be corrected this way. A table is rejected if its total is not full scale, if its order does not decrease, if a weight exceeds one plus the sum of the lower weights, if a weight has more than two set bits, or if any bit column would receive more than three ones. With the three-ones limit, one layer of full adders reduces the bit columns to two rows, and a ripple adder finishes the sum. An optional output register adds one cycle of latency and holds the code between valid words.

Top module: `sarc_corrector`

## Requirements
- R1: After reset and until the first accepted word, code_valid is 0 and code is 0.
- R2: code equals the sum of the table entries for the set raw bits, where raw_bits[i] carries entry i. The default table, from raw_bits[12] down to raw_bits[0], is 288, 256, 128, 128, 64, 64, 32, 32, 16, 8, 4, 2, 1.
- R3: For all 8192 raw words, the sum lies in 0..1023 and no carry leaves the 10-bit code width.
- R4: With the registered output, code and code_valid take the result on the first rising clock edge at which raw_valid is sampled high. code_valid is the value of raw_valid one cycle earlier.
- R5: With the registered output, a cycle in which raw_valid is low leaves code unchanged, whatever raw_bits carries.
- R6: For every input level 0..1023, an exact search produces a word that the block corrects to that level. In the exact search, decisions run from raw_bits[12] down to raw_bits[0], and a bit is 1 when the remaining residual is at least its weight.
- R7: In any of the first six decisions, choosing the opposite value still yields the exact level, provided the residual at that decision lies between the decision's weight and the sum of all lower weights.
- R8: The all-zero word gives code 0, and the all-ones word gives code 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_valid | input | 1 | Marks raw_bits as a complete decision word |
| raw_bits | input | N_RAW | Decision word, bit i weighted by table entry i |
| code_valid | output | 1 | Marks code as a new corrected result |
| code | output | N_OUT | Corrected binary code |

## Verification
A partial product routed from the wrong raw bit, or a wrong column in the full-adder layer, shows as a wrong code on the very next valid word that sets the affected bit. The exhaustive sweep over all raw words therefore exposes it within one cycle of the first such word. A broken carry in the ripple chain makes code differ from the weighted sum for every word whose columns generate that carry. A fault in the output register shows as a code that moves during idle cycles, or as a code_valid that does not follow raw_valid by exactly one cycle. The search sweeps, exact and with tolerated wrong decisions, tie the weight table itself to the level it must reproduce.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

   // Default geometry: 13 decisions folded into a 10-bit code.
   localparam int RAW_W_DEF  = 13;
   localparam int CODE_W_DEF = 10;

   // Largest number of ones allowed in one bit column of the addition.
   localparam int MAX_COL_H  = 3;

   // Default table, entry for raw bit 12 first. The top binary weight is
   // spread over 288, 128, 64 and 32, interleaved with the binary ones.
   localparam logic [RAW_W_DEF*CODE_W_DEF-1:0] WEIGHTS_DEF = {
      10'd288, 10'd256, 10'd128, 10'd128, 10'd64, 10'd64, 10'd32,
      10'd32,  10'd16,  10'd8,   10'd4,   10'd2,  10'd1
   };

endpackage

// File: rtl/sarc_pp_matrix.sv
module sarc_pp_matrix #(
   parameter int N_RAW = sarc_pkg::RAW_W_DEF,
   parameter int N_OUT = sarc_pkg::CODE_W_DEF,
   parameter int N_ROW = sarc_pkg::MAX_COL_H,
   parameter logic [N_RAW*N_OUT-1:0] WEIGHTS = sarc_pkg::WEIGHTS_DEF
) (
   input  logic [N_RAW-1:0]            raw,
   output logic [N_ROW-1:0][N_OUT-1:0] rows
);

   // Index of the raw bit that supplies the given slot of a column, or -1.
   function automatic int src_of(input int col, input int slot);
      int seen;
      int found;
      seen  = 0;
      found = -1;
      for (int i = 0; i < N_RAW; i++) begin
         if (WEIGHTS[i*N_OUT+col] && found < 0) begin
            if (seen == slot) found = i;
            seen++;
         end
      end
      return found;
   endfunction

   for (genvar c = 0; c < N_OUT; c++) begin : g_col
      for (genvar s = 0; s < N_ROW; s++) begin : g_slot
         localparam int SRC = src_of(c, s);
         if (SRC >= 0) begin : g_tap
            assign rows[s][c] = raw[SRC];
         end else begin : g_empty
            assign rows[s][c] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/sarc_fa_layer.sv
module sarc_fa_layer #(
   parameter int W = sarc_pkg::CODE_W_DEF
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s,
   output logic [W-1:0] cy
);

   for (genvar i = 0; i < W; i++) begin : g_fa
      assign s[i]  = a[i] ^ b[i] ^ c[i];
      assign cy[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
   end

endmodule

// File: rtl/sarc_cpa.sv
module sarc_cpa #(
   parameter int W = sarc_pkg::CODE_W_DEF
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] sum,
   output logic         cout
);

   logic [W:0] carry;

   assign carry[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = x[i] ^ y[i] ^ carry[i];
      assign carry[i+1] = (x[i] & y[i]) | (carry[i] & (x[i] ^ y[i]));
   end

   assign cout = carry[W];

endmodule

// File: rtl/sarc_corrector.sv
module sarc_corrector #(
   parameter int N_RAW = sarc_pkg::RAW_W_DEF,
   parameter int N_OUT = sarc_pkg::CODE_W_DEF,
   parameter logic [N_RAW*N_OUT-1:0] WEIGHTS = sarc_pkg::WEIGHTS_DEF,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_valid,
   input  logic [N_RAW-1:0] raw_bits,
   output logic             code_valid,
   output logic [N_OUT-1:0] code
);

   localparam int FULL  = (1 << N_OUT) - 1;
   localparam int N_ROW = sarc_pkg::MAX_COL_H;

   function automatic int wt(input int i);
      int v;
      v = 0;
      for (int b = 0; b < N_OUT; b++) begin
         if (WEIGHTS[i*N_OUT+b]) v += (1 << b);
      end
      return v;
   endfunction

   function automatic bit total_ok();
      int t;
      t = 0;
      for (int i = 0; i < N_RAW; i++) t += wt(i);
      return t == FULL;
   endfunction

   function automatic bit order_ok();
      bit ok;
      ok = 1'b1;
      for (int i = 1; i < N_RAW; i++) begin
         if (wt(i) < wt(i-1)) ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic bit cover_ok();
      bit ok;
      int lower;
      ok    = 1'b1;
      lower = 0;
      for (int i = 0; i < N_RAW; i++) begin
         if (wt(i) > lower + 1) ok = 1'b0;
         lower += wt(i);
      end
      return ok;
   endfunction

   function automatic bit shape_ok();
      bit ok;
      int ones;
      ok = 1'b1;
      for (int i = 0; i < N_RAW; i++) begin
         ones = 0;
         for (int b = 0; b < N_OUT; b++) begin
            if (WEIGHTS[i*N_OUT+b]) ones++;
         end
         if (ones == 0 || ones > 2) ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic bit height_ok();
      bit ok;
      int h;
      ok = 1'b1;
      for (int b = 0; b < N_OUT; b++) begin
         h = 0;
         for (int i = 0; i < N_RAW; i++) begin
            if (WEIGHTS[i*N_OUT+b]) h++;
         end
         if (h > N_ROW) ok = 1'b0;
      end
      return ok;
   endfunction

   // Table legality, settled at elaboration.
   if (N_OUT < 2 || N_OUT > 30) begin : g_bad_width
      $error("sarc_corrector: N_OUT out of the supported range");
   end
   if (!total_ok()) begin : g_bad_total
      $error("sarc_corrector: weights must add up to full scale");
   end
   if (!order_ok()) begin : g_bad_order
      $error("sarc_corrector: weights must not grow towards raw bit 0");
   end
   if (!cover_ok()) begin : g_bad_cover
      $error("sarc_corrector: a weight exceeds one plus all lower weights");
   end
   if (!shape_ok()) begin : g_bad_shape
      $error("sarc_corrector: each weight needs one or two set bits");
   end
   if (!height_ok()) begin : g_bad_height
      $error("sarc_corrector: a bit column holds more than three ones");
   end

   logic [N_ROW-1:0][N_OUT-1:0] pp_rows;
   logic [N_OUT-1:0]            csa_s;
   logic [N_OUT-1:0]            csa_c;
   logic [N_OUT-1:0]            sum_w;
   logic                        cpa_cout;
   logic                        sum_ovf;

   sarc_pp_matrix #(
      .N_RAW   (N_RAW),
      .N_OUT   (N_OUT),
      .N_ROW   (N_ROW),
      .WEIGHTS (WEIGHTS)
   ) u_pp (
      .raw  (raw_bits),
      .rows (pp_rows)
   );

   sarc_fa_layer #(.W(N_OUT)) u_csa (
      .a  (pp_rows[0]),
      .b  (pp_rows[1]),
      .c  (pp_rows[2]),
      .s  (csa_s),
      .cy (csa_c)
   );

   sarc_cpa #(.W(N_OUT)) u_cpa (
      .x    (csa_s),
      .y    ({csa_c[N_OUT-2:0], 1'b0}),
      .sum  (sum_w),
      .cout (cpa_cout)
   );

   // Any carry beyond the code width; the checker requires it to stay low.
   assign sum_ovf = cpa_cout | csa_c[N_OUT-1];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            code_valid <= 1'b0;
            code       <= '0;
         end else begin
            code_valid <= raw_valid;
            if (raw_valid) code <= sum_w;
         end
      end
   end else begin : g_comb
      assign code_valid = raw_valid;
      assign code       = sum_w;
   end

endmodule

// File: rtl/sarc_corrector_chk.sv
module sarc_corrector_chk #(
   parameter int N_RAW = sarc_pkg::RAW_W_DEF,
   parameter int N_OUT = sarc_pkg::CODE_W_DEF,
   parameter bit REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             raw_valid,
   input logic [N_RAW-1:0] raw_bits,
   input logic             code_valid,
   input logic [N_OUT-1:0] code,
   input logic             sum_ovf
);

   // R3: no accepted word produces a carry past the code width
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      raw_valid |-> !sum_ovf);

   if (REG_OUT) begin : g_reg
      // R4: result strobe trails the input strobe by one clock
      p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
         code_valid == $past(raw_valid));

      // R5: idle cycles leave the code untouched
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(raw_valid) |-> $stable(code));

      // R8: empty decision word corrects to zero
      p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(raw_valid) && $past(raw_bits) == '0) |-> code == '0);

      // R8: full decision word corrects to full scale
      p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(raw_valid) && (&$past(raw_bits))) |-> (&code));
   end else begin : g_comb
      // R4: without the register the strobe passes straight through
      p_valid_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
         code_valid == raw_valid);

      // R8: empty and full words at the boundary of the range
      p_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (raw_bits == '0) |-> code == '0);

      p_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (&raw_bits) |-> (&code));
   end

endmodule

bind sarc_corrector sarc_corrector_chk #(
   .N_RAW   (N_RAW),
   .N_OUT   (N_OUT),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .raw_valid  (raw_valid),
   .raw_bits   (raw_bits),
   .code_valid (code_valid),
   .code       (code),
   .sum_ovf    (sum_ovf)
);

// File: tb/sarc_corrector_bench.sv
module sarc_corrector_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NR         = 13;
   localparam int NO         = 10;
   localparam int WDOG       = 60000;

   // R2: table entry i belongs to raw bit i
   localparam int BW [NR] = '{1, 2, 4, 8, 16, 32, 32, 64, 64, 128, 128, 256, 288};

   logic          clk;
   logic          rst_n;
   logic          raw_valid;
   logic [NR-1:0] raw_bits;
   logic          code_valid;
   logic [NO-1:0] code;

   int    checks;
   int    fails;
   int    flips;
   bit    exp_valid;
   int    exp_code;
   string prev_tag;
   bit    done;

   sarc_corrector u_sarc_corrector (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_valid  (raw_valid),
      .raw_bits   (raw_bits),
      .code_valid (code_valid),
      .code       (code)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int wsum(input logic [NR-1:0] r);
      int t;
      t = 0;
      for (int i = 0; i < NR; i++) if (r[i]) t += BW[i];
      return t;
   endfunction

   task automatic check(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // One clock: compare the outputs caused by the previous stimulus,
   // then present the next one.
   task automatic step(input bit v, input logic [NR-1:0] r, input int expect_code,
                       input string tag);
      @(negedge clk);
      check(prev_tag, int'(code_valid), int'(exp_valid), "code_valid");
      check(prev_tag, int'(code), exp_code, "code");
      raw_valid = v;
      raw_bits  = r;
      exp_valid = v;
      if (v) exp_code = expect_code;
      prev_tag = tag;
   endtask

   // Behavioural search: MSB-first, optional wrong-but-tolerated decisions.
   task automatic search(input int level, input bit inject, output logic [NR-1:0] r);
      int e;
      int rest;
      bit take;
      e = level;
      r = '0;
      for (int i = NR - 1; i >= 0; i--) begin
         rest = 0;
         for (int j = 0; j < i; j++) rest += BW[j];
         take = (e >= BW[i]);
         if (inject && i >= NR - 6 && e >= BW[i] && e <= rest && ($urandom % 2 == 1)) begin
            take = !take;
            flips++;
         end
         if (take) begin
            r[i] = 1'b1;
            e -= BW[i];
         end
      end
   endtask

   initial begin
      checks    = 0;
      fails     = 0;
      flips     = 0;
      done      = 1'b0;
      exp_valid = 1'b0;
      exp_code  = 0;
      prev_tag  = "R1";
      rst_n     = 1'b0;
      raw_valid = 1'b0;
      raw_bits  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle cycles after reset show the reset state
      step(1'b0, '0, 0, "R1");
      step(1'b0, '1, 0, "R1");

      // R8: boundary words
      step(1'b1, '0, 0, "R8");
      step(1'b1, '1, 1023, "R8");

      // R2: each raw bit alone yields its own weight
      for (int i = 0; i < NR; i++) step(1'b1, NR'(1) << i, BW[i], "R2");

      // R4: single valid word between idle cycles
      step(1'b0, '0, 0, "R4");
      step(1'b1, 13'h0A5C, wsum(13'h0A5C), "R4");
      step(1'b0, '0, 0, "R4");

      // R5: idle cycles with changing garbage on raw_bits
      step(1'b1, 13'h1234, wsum(13'h1234), "R5");
      step(1'b0, 13'h1FFF, 0, "R5");
      step(1'b0, 13'h0000, 0, "R5");
      step(1'b0, 13'h0F0F, 0, "R5");

      // R3: every raw word against the weighted sum
      for (int w = 0; w < (1 << NR); w++) begin
         step(1'b1, NR'(w), wsum(NR'(w)), "R3");
      end

      // R6: exact search across every level
      for (int lv = 0; lv < 1024; lv++) begin
         logic [NR-1:0] r;
         search(lv, 1'b0, r);
         step(1'b1, r, lv, "R6");
      end

      // R7: two passes with tolerated early decision errors
      for (int pass = 0; pass < 2; pass++) begin
         for (int lv = 0; lv < 1024; lv++) begin
            logic [NR-1:0] r;
            search(lv, 1'b1, r);
            step(1'b1, r, lv, "R7");
         end
      end
      step(1'b0, '0, 0, "R7");

      // R7: the error injection actually happened
      checks++;
      if (flips == 0) begin
         fails++;
         $display("FAIL R7 injected flips: actual %0d expected >0", flips);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule